// File: doc/BRIEF.md
# Loop-Code Detector with Automatic Loopback

This block sits behind the clock-recovery stage of a line receiver and watches the recovered receive bits, one bit per clock-enable pulse, for two repeating in-band control codes. The first code asks the far end to start a line loopback. It is the five-bit sequence of four zeros followed by a one, repeated without a gap. The second code asks for the loopback to be released. It is the three-bit sequence of two zeros followed by a one, also repeated without a gap. A code only counts once it has been present without a break for a qualification time. That time is given in bit periods by a parameter: about five seconds of line time on silicon, and a few bits in simulation.

A two-bit mode input sets how the result is used. In the two manual modes the status bit simply follows the qualified presence of one chosen code. In automatic mode the block runs the loopback itself. A qualified loop-up code turns the remote-loopback enable on, and the block then waits for a qualified loop-down code to turn it off. In this mode the status bit mirrors the loopback state. Every change of the status bit can raise a sticky interrupt request, which is gated by an enable input and cleared by a one-cycle pulse.

Top module: `lpcode_det`

## Requirements
- R1: While rst_n is low and on the first clock after it rises, code_stat, rloop_en and irq are all 0.
- R2: A receive window matches the loop-up code when its last 5 bits are any phase of the repeating sequence 0,0,0,0,1. It matches the loop-down code when its last 3 bits are any phase of 0,0,1. One code stream never matches the other code.
- R3: A code qualifies once the count of consecutive matching bit windows reaches QUAL_BITS. Any accepted bit that breaks the pattern restarts that count at zero, so a code interrupted before QUAL_BITS matches never qualifies.
- R4: With mode 2'b01, code_stat follows loop-up qualification. With mode 2'b10, it follows loop-down qualification. It is set on the clock after the code qualifies and cleared on the clock after the first breaking bit. rloop_en stays 0 in both manual modes.
- R5: With mode 2'b00, code_stat and rloop_en are 0 from the next clock on, whatever is received.
- R6: On the first clock with mode 2'b11 after any other mode, code_stat and rloop_en are forced to 0 and the block waits for the loop-up code.
- R7: In mode 2'b11, a qualified loop-up code sets code_stat and rloop_en together on the same clock. Both stay at 1 after the loop-up code ends, for as long as loopback is active.
- R8: In mode 2'b11 with loopback active, a qualified loop-down code clears code_stat and rloop_en together.
- R9: When irq_en is 1, every rising or falling change of code_stat sets irq on the same clock. irq then stays at 1 until a clock on which irq_clr is 1.
- R10: When irq_en is 0, a change of code_stat leaves irq at 0.
- R11: rx_bit is ignored on clocks where bit_en is 0. Neither matching nor qualification advances on those clocks, so code_stat holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_en | input | 1 | Marks a clock that carries a new receive bit |
| rx_bit | input | 1 | Recovered receive data bit |
| mode | input | 2 | 00 off, 01 manual loop-up, 10 manual loop-down, 11 automatic |
| irq_en | input | 1 | Allows status changes to set the interrupt |
| irq_clr | input | 1 | One-cycle pulse that clears the interrupt |
| code_stat | output | 1 | Loop-code status bit |
| rloop_en | output | 1 | Remote loopback enable |
| irq | output | 1 | Sticky interrupt request |

## Verification
The stimulus uses an unbroken loop-up stream long enough to qualify, which shows that qualification works. A loop-up stream split by a single wrong bit into two runs shorter than the qualification time shows that the count restarts. A loop-down stream sent while the loop-up code is watched, and the reverse, tells the two codes apart. An all-zero stream during active loopback separates the latched automatic behaviour from the following manual one. Holding bit_en low while rx_bit carries junk shows that only enabled bits are taken. The mode changes, with the code already qualified, show the forced clear on entry to automatic mode and the hold at zero when detection is off.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_MAN_UP = 2'b01,
    MODE_MAN_DN = 2'b10,
    MODE_AUTO   = 2'b11
  } lpc_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_MAN  = 2'b01,
    ST_ARM  = 2'b10,
    ST_LOOP = 2'b11
  } lpc_state_e;

  typedef struct packed {
    logic up;
    logic dn;
  } lpc_qual_t;

  // code bit sequences, earliest received bit in the highest used position
  localparam int          CODE_MAX_LEN = 8;
  localparam int          UP_LEN  = 5;
  localparam logic [7:0]  UP_CODE = 8'b0000_0001;
  localparam int          DN_LEN  = 3;
  localparam logic [7:0]  DN_CODE = 8'b0000_0001;
  localparam int          NUM_CODES = 2;

endpackage

// File: rtl/lpc_track.sv
module lpc_track #(
  parameter int         LEN       = 5,
  parameter logic [7:0] CODE      = 8'b0000_0001,
  parameter int         QUAL_BITS = 16,
  parameter int         RUN_W     = $clog2(QUAL_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  output logic             qual,
  output logic [RUN_W-1:0] run
);

  localparam logic [2*LEN-1:0] DBL     = {CODE[LEN-1:0], CODE[LEN-1:0]};
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(QUAL_BITS);

  logic [LEN-1:0]   win_q, win_d, win_nx;
  logic [RUN_W-1:0] run_q, run_d;
  logic [LEN-1:0]   phase_hit;
  logic             hit;

  assign win_nx = {win_q[LEN-2:0], rx_bit};

  // compare the incoming window against every rotation of the code
  genvar r;
  generate
    for (r = 0; r < LEN; r++) begin : g_phase
      assign phase_hit[r] = (win_nx == DBL[r +: LEN]);
    end
  endgenerate

  assign hit = |phase_hit;

  always_comb begin
    win_d = win_q;
    run_d = run_q;
    if (bit_en) begin
      win_d = win_nx;
      if (hit) begin
        run_d = (run_q == RUN_TOP) ? run_q : run_q + 1'b1;
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      run_q <= '0;
    end else begin
      win_q <= win_d;
      run_q <= run_d;
    end
  end

  assign qual = (run_q == RUN_TOP);
  assign run  = run_q;

endmodule

// File: rtl/lpc_ctrl.sv
module lpc_ctrl
  import lpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lpc_mode_e mode,
  input  lpc_qual_t qual,
  output logic      stat_q,
  output logic      stat_nx,
  output logic      loop_q
);

  lpc_state_e st_q, st_d;
  logic       stat_d, loop_d;

  always_comb begin
    st_d   = st_q;
    stat_d = stat_q;
    loop_d = loop_q;
    unique case (mode)
      MODE_OFF: begin
        st_d   = ST_IDLE;
        stat_d = 1'b0;
        loop_d = 1'b0;
      end
      MODE_MAN_UP: begin
        st_d   = ST_MAN;
        stat_d = qual.up;
        loop_d = 1'b0;
      end
      MODE_MAN_DN: begin
        st_d   = ST_MAN;
        stat_d = qual.dn;
        loop_d = 1'b0;
      end
      MODE_AUTO: begin
        unique case (st_q)
          ST_ARM: begin
            if (qual.up) begin
              st_d   = ST_LOOP;
              stat_d = 1'b1;
              loop_d = 1'b1;
            end
          end
          ST_LOOP: begin
            if (qual.dn) begin
              st_d   = ST_ARM;
              stat_d = 1'b0;
              loop_d = 1'b0;
            end
          end
          default: begin
            st_d   = ST_ARM;
            stat_d = 1'b0;
            loop_d = 1'b0;
          end
        endcase
      end
      default: begin
        st_d   = ST_IDLE;
        stat_d = 1'b0;
        loop_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      stat_q <= 1'b0;
      loop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      stat_q <= stat_d;
      loop_q <= loop_d;
    end
  end

  assign stat_nx = stat_d;

endmodule

// File: rtl/lpc_irq.sv
module lpc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_en,
  input  logic irq_clr,
  input  logic stat_q,
  input  logic stat_nx,
  output logic irq_q
);

  logic irq_d;
  logic toggle;

  assign toggle = stat_q ^ stat_nx;

  always_comb begin
    irq_d = irq_q & ~irq_clr;
    if (irq_en && toggle) begin
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/lpcode_det.sv
module lpcode_det
  import lpc_pkg::*;
#(
  parameter int QUAL_BITS = 7_720_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       rx_bit,
  input  logic [1:0] mode,
  input  logic       irq_en,
  input  logic       irq_clr,
  output logic       code_stat,
  output logic       rloop_en,
  output logic       irq
);

  localparam int RUN_W = $clog2(QUAL_BITS + 1);

  logic [NUM_CODES-1:0] qual_v;
  logic [RUN_W-1:0]     run_v [NUM_CODES];
  lpc_qual_t            qual_s;
  logic                 stat_q, stat_nx, loop_q;

  genvar g;
  generate
    for (g = 0; g < NUM_CODES; g++) begin : g_code
      localparam int         LEN_G  = (g == 0) ? UP_LEN  : DN_LEN;
      localparam logic [7:0] CODE_G = (g == 0) ? UP_CODE : DN_CODE;
      lpc_track #(
        .LEN       (LEN_G),
        .CODE      (CODE_G),
        .QUAL_BITS (QUAL_BITS),
        .RUN_W     (RUN_W)
      ) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .rx_bit (rx_bit),
        .qual   (qual_v[g]),
        .run    (run_v[g])
      );
    end
  endgenerate

  assign qual_s.up = qual_v[0];
  assign qual_s.dn = qual_v[1];

  lpc_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (lpc_mode_e'(mode)),
    .qual    (qual_s),
    .stat_q  (stat_q),
    .stat_nx (stat_nx),
    .loop_q  (loop_q)
  );

  lpc_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_en  (irq_en),
    .irq_clr (irq_clr),
    .stat_q  (stat_q),
    .stat_nx (stat_nx),
    .irq_q   (irq)
  );

  assign code_stat = stat_q;
  assign rloop_en  = loop_q;

endmodule

// File: rtl/lpcode_det_chk.sv
module lpcode_det_chk #(
  parameter int QUAL_BITS = 16,
  parameter int RUN_W     = $clog2(QUAL_BITS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic [1:0]       mode,
  input logic             irq_en,
  input logic             irq_clr,
  input logic             code_stat,
  input logic             rloop_en,
  input logic             irq,
  input logic [RUN_W-1:0] up_run,
  input logic [RUN_W-1:0] dn_run
);

  // R7: loopback never runs without the status bit
  p_loop_has_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rloop_en |-> code_stat);

  // R4: manual modes never enable loopback
  p_manual_noloop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 || mode == 2'b10) |=> !rloop_en);

  // R5: detection off holds both outputs low
  p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (!code_stat && !rloop_en));

  // R6: entering automatic mode clears the status
  p_auto_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && $past(mode) != 2'b11) |=> (!code_stat && !rloop_en));

  // R9: an enabled status change raises the interrupt
  p_irq_on_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_en) && (code_stat != $past(code_stat))) |-> irq);

  // R9: the interrupt is sticky until cleared
  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq) && !$past(irq_clr)) |-> irq);

  // R10: a disabled interrupt never rises
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(irq) && !$past(irq_en)) |-> !irq);

  // R11: no bit enable, no progress on either qualification count
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(up_run) && $stable(dn_run)));

endmodule

bind lpcode_det lpcode_det_chk #(
  .QUAL_BITS (QUAL_BITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .mode      (mode),
  .irq_en    (irq_en),
  .irq_clr   (irq_clr),
  .code_stat (code_stat),
  .rloop_en  (rloop_en),
  .irq       (irq),
  .up_run    (run_v[0]),
  .dn_run    (run_v[1])
);

// File: tb/sim_lpcode_det.sv
module sim_lpcode_det;

  localparam int Q = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en;
  logic       rx_bit;
  logic [1:0] mode;
  logic       irq_en;
  logic       irq_clr;
  logic       code_stat;
  logic       rloop_en;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  lpcode_det #(.QUAL_BITS(Q)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .rx_bit    (rx_bit),
    .mode      (mode),
    .irq_en    (irq_en),
    .irq_clr   (irq_clr),
    .code_stat (code_stat),
    .rloop_en  (rloop_en),
    .irq       (irq)
  );

  // ---------------- behavioural reference ----------------
  bit hist_up[$];
  bit hist_dn[$];
  int run_up, run_dn;
  int m_state;          // 0 off, 1 manual, 2 armed, 3 looping
  bit m_stat, m_loop, m_irq;

  function automatic int ones(bit q[$]);
    int n = 0;
    foreach (q[i]) n += q[i];
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_up = '{0, 0, 0, 0, 0};
      hist_dn = '{0, 0, 0};
      run_up = 0; run_dn = 0;
      m_state = 0; m_stat = 0; m_loop = 0; m_irq = 0;
    end else begin
      bit qu, qd, new_stat, new_loop;
      qu = (run_up == Q);
      qd = (run_dn == Q);
      new_stat = m_stat;
      new_loop = m_loop;
      case (mode)
        2'b00: begin m_state = 0; new_stat = 0; new_loop = 0; end
        2'b01: begin m_state = 1; new_stat = qu; new_loop = 0; end
        2'b10: begin m_state = 1; new_stat = qd; new_loop = 0; end
        default: begin
          if (m_state == 2) begin
            if (qu) begin m_state = 3; new_stat = 1; new_loop = 1; end
          end else if (m_state == 3) begin
            if (qd) begin m_state = 2; new_stat = 0; new_loop = 0; end
          end else begin
            m_state = 2; new_stat = 0; new_loop = 0;
          end
        end
      endcase
      m_irq  = (m_irq && !irq_clr) || (irq_en && (new_stat != m_stat));
      m_stat = new_stat;
      m_loop = new_loop;
      if (bit_en) begin
        hist_up.push_back(rx_bit); void'(hist_up.pop_front());
        hist_dn.push_back(rx_bit); void'(hist_dn.pop_front());
        // a window of one repeating code holds exactly one set bit
        run_up = (ones(hist_up) == 1) ? ((run_up < Q) ? run_up + 1 : Q) : 0;
        run_dn = (ones(hist_dn) == 1) ? ((run_dn < Q) ? run_dn + 1 : Q) : 0;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(code_stat == m_stat, "cycle model code_stat", code_stat, m_stat);
      check(rloop_en == m_loop, "cycle model rloop_en", rloop_en, m_loop);
      check(irq == m_irq, "cycle model irq", irq, m_irq);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    @(negedge clk); rx_bit = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic send_up(int periods);
    repeat (periods) begin
      send_bit(0); send_bit(0); send_bit(0); send_bit(0); send_bit(1);
    end
  endtask

  task automatic send_dn(int periods);
    repeat (periods) begin
      send_bit(0); send_bit(0); send_bit(1);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic set_mode(logic [1:0] v);
    @(negedge clk); mode = v;
  endtask

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0;
    mode = 2'b00; irq_en = 1'b0; irq_clr = 1'b0;
    idle(3);
    check(code_stat == 0, "R1 stat in reset", code_stat, 0);
    check(rloop_en == 0, "R1 loop in reset", rloop_en, 0);
    check(irq == 0, "R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    idle(1);
    check(code_stat == 0 && rloop_en == 0 && irq == 0, "R1 after release",
          {code_stat, rloop_en, irq}, 0);

    // manual loop-up
    mode = 2'b01; irq_en = 1'b1;
    send_up(4); idle(2);
    check(code_stat == 1, "R4 manual up qualifies", code_stat, 1);
    check(rloop_en == 0, "R4 manual no loopback", rloop_en, 0);
    check(irq == 1, "R9 irq on rise", irq, 1);
    pulse_clr();
    check(irq == 0, "R9 irq cleared", irq, 0);
    send_bit(1); idle(1);
    check(code_stat == 0, "R4 clears on break", code_stat, 0);
    check(irq == 1, "R9 irq on fall", irq, 1);
    pulse_clr();

    // restart of qualification
    send_up(2); send_bit(1); send_up(2); idle(2);
    check(code_stat == 0, "R3 broken runs do not qualify", code_stat, 0);
    send_up(3); idle(2);
    check(code_stat == 1, "R3 unbroken run qualifies", code_stat, 1);
    send_bit(1); send_bit(1); idle(2);
    pulse_clr();

    // code discrimination
    send_dn(10); idle(2);
    check(code_stat == 0, "R2 down code ignored by up watch", code_stat, 0);
    set_mode(2'b10); idle(2);
    check(code_stat == 1, "R2 down code seen by down watch", code_stat, 1);
    send_bit(1); idle(1);
    check(code_stat == 0, "R4 manual down clears on break", code_stat, 0);
    pulse_clr();

    // bit enable gating
    set_mode(2'b01);
    send_up(4); idle(2);
    check(code_stat == 1, "R4 requalify up", code_stat, 1);
    rx_bit = 1'b1;
    idle(30);
    check(code_stat == 1, "R11 junk without bit_en ignored", code_stat, 1);
    pulse_clr();

    // detection off
    set_mode(2'b00); idle(2);
    check(code_stat == 0 && rloop_en == 0, "R5 off holds low",
          {code_stat, rloop_en}, 0);
    pulse_clr();

    // masked interrupt
    irq_en = 1'b0;
    set_mode(2'b01); idle(2);
    check(code_stat == 1, "R10 status still moves", code_stat, 1);
    check(irq == 0, "R10 irq masked", irq, 0);
    irq_en = 1'b1;

    // automatic mode
    set_mode(2'b11);
    @(negedge clk);
    check(code_stat == 0 && rloop_en == 0, "R6 entry forces clear",
          {code_stat, rloop_en}, 0);
    @(negedge clk);
    check(code_stat == 1 && rloop_en == 1, "R7 loop-up starts loopback",
          {code_stat, rloop_en}, 3);
    repeat (40) send_bit(0);
    idle(2);
    check(code_stat == 1 && rloop_en == 1, "R7 loopback persists",
          {code_stat, rloop_en}, 3);
    send_dn(8); idle(2);
    check(code_stat == 0 && rloop_en == 0, "R8 loop-down releases",
          {code_stat, rloop_en}, 0);
    check(irq == 1, "R9 irq in auto mode", irq, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule